// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block steps the system devices through a power-saving change of clock frequency. Software writes a one-hot frequency code into a control register. When that write turns on exactly one legal code bit that was off before, the block freezes the system by driving its active-low freeze output low. It then waits for the freeze acknowledge handshake and applies a chain of programmable delays. In order, it drives a three-line active-low clock-change bus low, raises a PLL bypass output, drops the bypass, releases the clock-change bus, and finally releases freeze. A one-cycle done pulse closes the sequence.

Each phase length comes from its own timing input. The counts are in controller clocks, and the controller clock runs at half the system frequency. Software clears the control register a few controller clocks after setting it. The block treats that clear, and any other write made while a sequence is running, as having no effect on the sequence.

The state machine walks IDLE, FREEZE, WAIT_ACK, ASSERT_DELAY, CHANGE, BYPASS, DEASSERT, SETTLE, DONE and then returns to IDLE. The transitions are:
- IDLE to FREEZE on a legal start.
- FREEZE to WAIT_ACK unconditionally.
- WAIT_ACK to ASSERT_DELAY when the acknowledge is seen.
- From each timed state to the next when its delay counter has run out.
- DONE back to IDLE unconditionally.

Top module: `freq_change_seq`

## Requirements
- R1: After reset, `freeze_n` is 1, `chg_n` is all ones, `pll_bypass`, `done` and `busy` are 0, and `freq_code` is 0.
- R2: In IDLE, a write whose data is exactly one of 0x01 (full), 0x02 (half) or 0x20 (1/32), with that bit 0 in the stored control value, starts a sequence. On the clock after the write, `busy` is 1, `freeze_n` is 0 and `freq_code` holds the written code.
- R3: A write with more than one bit set, or with any bit of mask 0xDC set, starts nothing.
- R4: A write that sets no bit from 0 to 1 starts nothing. This covers a clear to 0x00, a rewrite of the stored value, and a legal code whose bit was already 1.
- R5: The block stays in WAIT_ACK until `freeze_ack` is sampled high. It then spends `dly_ack_to_chg`+1 clocks in ASSERT_DELAY before all `chg_n` lines go low.
- R6: `pll_bypass` rises `dly_chg_to_byp`+1 clocks after `chg_n` goes low.
- R7: `pll_bypass` stays high for `dly_byp_hold`+1 clocks. `chg_n` stays low for `dly_chg_hold`+1 further clocks and then returns to all ones.
- R8: `freeze_n` returns to 1 `dly_settle`+1 clocks after `chg_n` is released. In that same clock `done` is high for exactly one clock, and the next clock finds the block idle.
- R9: Writes made while `busy` is 1 change neither the phase timing nor `freq_code`, and they leave no pending start behind.
- R10: A delay value of 0 makes its phase last a single clock.
- R11: `chg_n` lines switch together, `chg_n` is low only while `freeze_n` is low, and `pll_bypass` is high only while `chg_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (half the system frequency) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr_en | input | 1 | Control register write strobe |
| ctrl_wr_data | input | CTRL_W (8) | Control register write data (frequency code) |
| dly_ack_to_chg | input | ACT_W (8) | Clocks from acknowledge to clock-change assertion, minus one |
| dly_chg_to_byp | input | ABT_W (16) | Clocks from clock-change assertion to bypass assertion, minus one |
| dly_byp_hold | input | DABT_W (8) | Bypass hold time, minus one |
| dly_chg_hold | input | DACT_W (8) | Clock-change hold after bypass drop, minus one |
| dly_settle | input | PST_W (32) | PLL settle time before freeze release, minus one |
| freeze_ack | input | 1 | Freeze acknowledge from the system devices |
| freeze_n | output | 1 | Active-low freeze request |
| chg_n | output | CHG_LINES (3) | Active-low clock-change lines |
| pll_bypass | output | 1 | PLL bypass request |
| freq_code | output | CTRL_W (8) | Code latched at the accepted start |
| busy | output | 1 | High while a sequence is in progress |
| done | output | 1 | One-clock pulse when the sequence completes |

## Verification
Each of the three codes starts a sequence, and each uses a different delay set. One set is all zeros, one has small unequal values, and one has a late acknowledge. Because of this, an off-by-one in any single phase, or a missing wait on the handshake, moves a different measured edge. Writes that are illegal are checked separately from writes that are only non-rising: two-bit words, reserved bits, rewrites, clears, and a legal code whose bit was already set. This shows apart the one-hot test from the rising-edge test. Writes issued mid-sequence show whether a busy sequence is disturbed, and whether a start is left queued for later.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FREEZE,
        ST_WAIT_ACK,
        ST_ASSERT_DELAY,
        ST_CHANGE,
        ST_BYPASS,
        ST_DEASSERT,
        ST_SETTLE,
        ST_DONE
    } fcs_state_e;

    localparam logic [7:0] CODE_FULL_SPEED = 8'h01;
    localparam logic [7:0] CODE_HALF_SPEED = 8'h02;
    localparam logic [7:0] CODE_SLOW_SPEED = 8'h20;

endpackage

// File: rtl/fcs_trigger.sv
// Control register and start detector: a start needs a write that is one-hot,
// uses only legal code bits, and raises a bit that was clear before.
module fcs_trigger #(
    parameter int                 CTRL_W     = 8,
    parameter logic [CTRL_W-1:0]  VALID_MASK = 8'h23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              allow,
    output logic              start
);

    logic [CTRL_W-1:0] ctrl_q;
    logic [CTRL_W-1:0] rising_bits;
    logic              only_legal;
    logic              single_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end

    always_comb begin
        rising_bits = wr_data & ~ctrl_q;
        only_legal  = ((wr_data & ~VALID_MASK) == '0);
        single_bit  = $onehot(wr_data);
        start       = wr_en && allow && only_legal && single_bit && (rising_bits != '0);
    end

endmodule

// File: rtl/fcs_delay.sv
// Shared phase counter: loaded on entry to a timed state, counts down to zero.
module fcs_delay #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/freq_change_seq.sv
module freq_change_seq
    import fcs_pkg::*;
#(
    parameter int CTRL_W    = 8,
    parameter int CHG_LINES = 3,
    parameter int ACT_W     = 8,
    parameter int ABT_W     = 16,
    parameter int DABT_W    = 8,
    parameter int DACT_W    = 8,
    parameter int PST_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr_en,
    input  logic [CTRL_W-1:0]    ctrl_wr_data,
    input  logic [ACT_W-1:0]     dly_ack_to_chg,
    input  logic [ABT_W-1:0]     dly_chg_to_byp,
    input  logic [DABT_W-1:0]    dly_byp_hold,
    input  logic [DACT_W-1:0]    dly_chg_hold,
    input  logic [PST_W-1:0]     dly_settle,
    input  logic                 freeze_ack,
    output logic                 freeze_n,
    output logic [CHG_LINES-1:0] chg_n,
    output logic                 pll_bypass,
    output logic [CTRL_W-1:0]    freq_code,
    output logic                 busy,
    output logic                 done
);

    localparam int W_A   = (ACT_W > ABT_W) ? ACT_W : ABT_W;
    localparam int W_B   = (DABT_W > DACT_W) ? DABT_W : DACT_W;
    localparam int W_AB  = (W_A > W_B) ? W_A : W_B;
    localparam int CNT_W = (W_AB > PST_W) ? W_AB : PST_W;

    localparam logic [CTRL_W-1:0] VALID_MASK =
        CTRL_W'(CODE_FULL_SPEED) | CTRL_W'(CODE_HALF_SPEED) | CTRL_W'(CODE_SLOW_SPEED);

    fcs_state_e        state_q, state_d;
    logic              start;
    logic              expired;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_load_val;
    logic [CTRL_W-1:0] code_q;

    fcs_trigger #(
        .CTRL_W     (CTRL_W),
        .VALID_MASK (VALID_MASK)
    ) u_trigger (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctrl_wr_en),
        .wr_data (ctrl_wr_data),
        .allow   (state_q == ST_IDLE),
        .start   (start)
    );

    fcs_delay #(
        .CNT_W (CNT_W)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .expired  (expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Latched frequency code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (start) begin
            code_q <= ctrl_wr_data;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:         if (start)      state_d = ST_FREEZE;
            ST_FREEZE:                       state_d = ST_WAIT_ACK;
            ST_WAIT_ACK:     if (freeze_ack) state_d = ST_ASSERT_DELAY;
            ST_ASSERT_DELAY: if (expired)    state_d = ST_CHANGE;
            ST_CHANGE:       if (expired)    state_d = ST_BYPASS;
            ST_BYPASS:       if (expired)    state_d = ST_DEASSERT;
            ST_DEASSERT:     if (expired)    state_d = ST_SETTLE;
            ST_SETTLE:       if (expired)    state_d = ST_DONE;
            ST_DONE:                         state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Phase counter load: each timed state gets its delay on entry
    always_comb begin
        cnt_load     = (state_d != state_q);
        cnt_load_val = '0;
        unique case (state_d)
            ST_ASSERT_DELAY: cnt_load_val = CNT_W'(dly_ack_to_chg);
            ST_CHANGE:       cnt_load_val = CNT_W'(dly_chg_to_byp);
            ST_BYPASS:       cnt_load_val = CNT_W'(dly_byp_hold);
            ST_DEASSERT:     cnt_load_val = CNT_W'(dly_chg_hold);
            ST_SETTLE:       cnt_load_val = CNT_W'(dly_settle);
            default:         cnt_load_val = '0;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        freeze_n   = 1'b1;
        chg_n      = '1;
        pll_bypass = 1'b0;
        done       = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE:         busy = 1'b0;
            ST_FREEZE:       freeze_n = 1'b0;
            ST_WAIT_ACK:     freeze_n = 1'b0;
            ST_ASSERT_DELAY: freeze_n = 1'b0;
            ST_CHANGE: begin
                freeze_n = 1'b0;
                chg_n    = '0;
            end
            ST_BYPASS: begin
                freeze_n   = 1'b0;
                chg_n      = '0;
                pll_bypass = 1'b1;
            end
            ST_DEASSERT: begin
                freeze_n = 1'b0;
                chg_n    = '0;
            end
            ST_SETTLE:       freeze_n = 1'b0;
            ST_DONE:         done = 1'b1;
            default:         busy = 1'b0;
        endcase
    end

    assign freq_code = code_q;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int CTRL_W    = 8,
    parameter int CHG_LINES = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 freeze_n,
    input logic [CHG_LINES-1:0] chg_n,
    input logic                 pll_bypass,
    input logic [CTRL_W-1:0]    freq_code,
    input logic                 busy,
    input logic                 done
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (freeze_n && (chg_n == '1) && !pll_bypass && !done));

    assert_start_freezes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !freeze_n);

    assert_bypass_after_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_bypass) |-> $past(chg_n == '0));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_releases_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (freeze_n && $past(!freeze_n)));

    assert_code_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(freq_code));

    assert_chg_together_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_n == '0) || (chg_n == '1));

    assert_chg_inside_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_n != '1) |-> !freeze_n);

    assert_bypass_inside_chg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass |-> (chg_n == '0));

endmodule

bind freq_change_seq fcs_checker #(
    .CTRL_W    (CTRL_W),
    .CHG_LINES (CHG_LINES)
) u_fcs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_n   (freeze_n),
    .chg_n      (chg_n),
    .pll_bypass (pll_bypass),
    .freq_code  (freq_code),
    .busy       (busy),
    .done       (done)
);

// File: tb/freq_change_seq_test.sv
`timescale 1ns/1ps
module freq_change_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr_en = 1'b0;
    logic [7:0]  ctrl_wr_data = 8'h00;
    logic [7:0]  dly_ack_to_chg = '0;
    logic [15:0] dly_chg_to_byp = '0;
    logic [7:0]  dly_byp_hold = '0;
    logic [7:0]  dly_chg_hold = '0;
    logic [31:0] dly_settle = '0;
    logic        freeze_ack = 1'b0;
    logic        freeze_n;
    logic [2:0]  chg_n;
    logic        pll_bypass;
    logic [7:0]  freq_code;
    logic        busy;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    freq_change_seq uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctrl_wr_en     (ctrl_wr_en),
        .ctrl_wr_data   (ctrl_wr_data),
        .dly_ack_to_chg (dly_ack_to_chg),
        .dly_chg_to_byp (dly_chg_to_byp),
        .dly_byp_hold   (dly_byp_hold),
        .dly_chg_hold   (dly_chg_hold),
        .dly_settle     (dly_settle),
        .freeze_ack     (freeze_ack),
        .freeze_n       (freeze_n),
        .chg_n          (chg_n),
        .pll_bypass     (pll_bypass),
        .freq_code      (freq_code),
        .busy           (busy),
        .done           (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    task automatic t_reset();
        check(freeze_n == 1'b1, "R1", "freeze_n after reset", int'(freeze_n), 1);
        check(chg_n == 3'b111, "R1", "chg_n after reset", int'(chg_n), 7);
        check(pll_bypass == 1'b0, "R1", "pll_bypass after reset", int'(pll_bypass), 0);
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done after reset",
              int'({busy, done}), 0);
        check(freq_code == 8'h00, "R1", "freq_code after reset", int'(freq_code), 0);
    endtask

    // Write, then watch for quiet cycles: nothing may start.
    task automatic t_no_start(input bit do_write, input logic [7:0] val,
                              input string req, input string what);
        int moved = 0;
        @(negedge clk);
        if (do_write) begin
            ctrl_wr_en   = 1'b1;
            ctrl_wr_data = val;
        end
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ctrl_wr_en = 1'b0;
            if (busy || !freeze_n || chg_n != 3'b111) moved++;
        end
        check(moved == 0, req, what, moved, 0);
    endtask

    // Run one full sequence and check every edge position.
    task automatic t_run(input logic [7:0] code, input int a, input int b, input int c,
                         input int d, input int p, input int ack_at,
                         input int mid_at, input logic [7:0] mid_val, input string name);
        int k;
        int ev_chg = -1, ev_byp_on = -1, ev_byp_off = -1, ev_chg_off = -1;
        int ev_done = -1, ev_idle = -1;
        int done_cnt = 0, incoherent = 0;
        logic prev_chg_low = 1'b0, prev_byp = 1'b0;
        logic s1_freeze_n = 1'b1, s1_busy = 1'b0;
        logic [7:0] s1_code = 8'h00;
        k = (ack_at < 2) ? 2 : ack_at;
        dly_ack_to_chg = 8'(a);
        dly_chg_to_byp = 16'(b);
        dly_byp_hold   = 8'(c);
        dly_chg_hold   = 8'(d);
        dly_settle     = 32'(p);
        @(negedge clk);
        freeze_ack   = (ack_at < 2);
        ctrl_wr_en   = 1'b1;
        ctrl_wr_data = code;
        for (int i = 1; i < 400 && ev_idle < 0; i++) begin
            @(negedge clk);
            ctrl_wr_en = 1'b0;
            if (i == 1) begin
                s1_freeze_n = freeze_n;
                s1_busy     = busy;
                s1_code     = freq_code;
            end
            if ((chg_n != 3'b111 && freeze_n) || (pll_bypass && chg_n != 3'b000) ||
                (chg_n != 3'b111 && chg_n != 3'b000))
                incoherent++;
            if (chg_n == 3'b000 && !prev_chg_low && ev_chg < 0) ev_chg = i;
            if (chg_n == 3'b111 && prev_chg_low && ev_chg_off < 0) ev_chg_off = i;
            if (pll_bypass && !prev_byp && ev_byp_on < 0) ev_byp_on = i;
            if (!pll_bypass && prev_byp && ev_byp_off < 0) ev_byp_off = i;
            if (done) begin
                done_cnt++;
                if (ev_done < 0) ev_done = i;
            end
            if (ev_done >= 0 && !busy && i > ev_done) ev_idle = i;
            prev_chg_low = (chg_n == 3'b000);
            prev_byp     = pll_bypass;
            if (i == ack_at) freeze_ack = 1'b1;
            if (i == mid_at) begin
                ctrl_wr_en   = 1'b1;
                ctrl_wr_data = mid_val;
            end
        end
        freeze_ack = 1'b0;
        check(s1_busy && !s1_freeze_n, "R2", {name, " freeze one clock after write"},
              int'({s1_busy, s1_freeze_n}), 2);
        check(s1_code == code, "R2", {name, " freq_code latched"}, int'(s1_code), int'(code));
        check(ev_chg == k + 2 + a, "R5", {name, " chg_n low after ack delay"},
              ev_chg, k + 2 + a);
        check(ev_byp_on == k + 3 + a + b, "R6", {name, " bypass rise"},
              ev_byp_on, k + 3 + a + b);
        check(ev_byp_off == k + 4 + a + b + c, "R7", {name, " bypass fall"},
              ev_byp_off, k + 4 + a + b + c);
        check(ev_chg_off == k + 5 + a + b + c + d, "R7", {name, " chg_n release"},
              ev_chg_off, k + 5 + a + b + c + d);
        check(ev_done == k + 6 + a + b + c + d + p, "R8", {name, " done/freeze release"},
              ev_done, k + 6 + a + b + c + d + p);
        check(done_cnt == 1 && ev_idle == ev_done + 1, "R8", {name, " single done then idle"},
              done_cnt, 1);
        check(freq_code == code, "R9", {name, " freq_code held to end"},
              int'(freq_code), int'(code));
        check(incoherent == 0, "R11", {name, " output coherence"}, incoherent, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        // Full speed, small distinct delays, software clear mid-sequence (R9)
        t_run(8'h01, 2, 3, 1, 1, 4, 0, 8, 8'h00, "full");
        // Half speed, every delay zero (R10)
        t_run(8'h02, 0, 0, 0, 0, 0, 0, -1, 8'h00, "half_zero_R10");
        // 1/32 speed, late acknowledge (R5), a new legal code written while busy (R9)
        t_run(8'h20, 1, 0, 2, 0, 3, 10, 5, 8'h01, "slow_late_ack");

        // Stored value is now 0x01
        t_no_start(1'b1, 8'h01, "R4", "rewrite of stored code");
        t_no_start(1'b1, 8'h00, "R4", "clear to zero");
        t_no_start(1'b1, 8'h03, "R3", "two bits set");
        t_no_start(1'b1, 8'h02, "R4", "legal code whose bit was already set");
        t_no_start(1'b1, 8'h00, "R4", "clear before reserved test");
        t_no_start(1'b1, 8'h04, "R3", "reserved bit");
        t_no_start(1'b1, 8'h21, "R3", "two legal bits set");
        t_no_start(1'b1, 8'h00, "R4", "clear before last run");

        // Busy-time write of a rising legal code leaves nothing pending (R9)
        t_run(8'h20, 3, 2, 1, 2, 5, 4, 6, 8'h02, "slow_busy_write_R9");
        t_no_start(1'b0, 8'h00, "R9", "no pending start after busy write");
        t_no_start(1'b1, 8'h02, "R4", "rewrite after busy write");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule